// File: doc/BRIEF.md
# Legacy Display Memory Access Trap

This block watches the physical address of each memory access issued by a processor core and decides, in the same cycle, whether the access lands in the legacy display memory window (A0000h through BFFFFh). It drives two outputs. The first is a routing flag that tells the graphics pipeline to take over the read or write. The second is an interrupt request that hands the access to system-management emulation code. Because later instructions may run once a buffered write has left the core, both outputs are purely combinational from the presented address and the stored configuration.

Three parts of the window can be trapped separately: the 64 KB graphics area at A0000h, the 32 KB monochrome text area at B0000h, and the 32 KB colour text area at B8000h. A 32-bit region mask holds one bit per 2 KB region of a 64 KB mask window. Each bit decides whether a trapped access in that region raises the interrupt, so emulation code can stop the interrupt for regions that are not on screen. The mask window starts at A0000h or B0000h. A global enable bit can silence the interrupt while routing carries on. The configuration is held in two registers, each loaded through a plain write strobe and data port.

Top module: `vgat_top`

## Requirements
- R1: After reset the control register is zero, with all sub-ranges disabled and the interrupt disabled, and the region mask is all ones. No access produces an output until the control register is written.
- R2: With acc_valid high, acc_route is high in the same cycle if the address lies in an enabled sub-range. Control bit 0 enables A0000h–AFFFFh, bit 1 enables B0000h–B7FFFh and bit 2 enables B8000h–BFFFFh.
- R3: While acc_valid is low, acc_route and acc_smi are both low whatever the address.
- R4: An address outside every enabled sub-range asserts neither output. This includes any address below A0000h, any address above BFFFFh, and any address with a bit above bit 19 set.
- R5: acc_smi is high only when acc_route is high, control bit 4 (interrupt enable) is set, and the region gate is open.
- R6: Control bit 3 selects the mask window base: 0 gives A0000h and 1 gives B0000h. The window spans 64 KB. The region index is address bits [15:11] taken relative to the base, and mask bit n gates region n (1 lets the interrupt through, 0 blocks it).
- R7: A routed access that falls outside the mask window raises acc_smi without gating, provided the interrupt enable is set.
- R8: With control bit 4 clear, acc_smi stays low while acc_route behaves exactly as when it is set.
- R9: Both outputs follow the address and acc_valid in the same cycle, with no register stage.
- R10: A value presented with cfg_ctl_we or cfg_mask_we takes effect from the cycle after the rising clock edge that captures it. An access in the write cycle still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Physical address of the access |
| cfg_ctl_we | input | 1 | Write strobe for the control register |
| cfg_ctl_data | input | 5 | Control value: [2:0] sub-range enables, [3] mask window base, [4] interrupt enable |
| cfg_mask_we | input | 1 | Write strobe for the region mask |
| cfg_mask_data | input | 32 | Region mask value, one bit per 2 KB region |
| acc_route | output | 1 | Access belongs to the graphics pipeline |
| acc_smi | output | 1 | System-management interrupt request for this access |

## Verification
The outputs have no register stage, so a wrong stored configuration shows on the first access that touches the affected field, in the cycle the access is presented. A corrupted sub-range enable appears as a missing or extra routing flag for addresses in that span. A corrupted mask bit or base select shows only as a wrong interrupt on its own 2 KB region, or on the edge between the two possible windows. For that reason the bench sweeps the region indices and both window bases against a behavioural model on every clock, rather than testing a few sample addresses.

// File: rtl/vgat_pkg.sv
package vgat_pkg;
  localparam int ADDR_W       = 32;
  localparam int NUM_SUB      = 3;
  localparam int NUM_REGIONS  = 32;
  localparam int REGION_SHIFT = 11;
  localparam int IDX_W        = $clog2(NUM_REGIONS);
  localparam int WIN_BYTES    = NUM_REGIONS << REGION_SHIFT;
  localparam int CTL_W        = NUM_SUB + 2;

  localparam logic [ADDR_W-1:0] SUB_LO [NUM_SUB] = '{32'h000A_0000, 32'h000B_0000, 32'h000B_8000};
  localparam logic [ADDR_W-1:0] SUB_HI [NUM_SUB] = '{32'h000A_FFFF, 32'h000B_7FFF, 32'h000B_FFFF};
  localparam logic [ADDR_W-1:0] WIN_BASE_LO = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] WIN_BASE_HI = 32'h000B_0000;

  typedef struct packed {
    logic               irq_en;
    logic               base_hi;
    logic [NUM_SUB-1:0] sub_en;
  } ctl_t;

  function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] lo,
                                   input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [ADDR_W-1:0] win_offset(input logic [ADDR_W-1:0] a,
                                                   input logic base_hi);
    return a - (base_hi ? WIN_BASE_HI : WIN_BASE_LO);
  endfunction

  function automatic logic [IDX_W-1:0] region_of(input logic [ADDR_W-1:0] offs);
    return offs[REGION_SHIFT +: IDX_W];
  endfunction
endpackage

// File: rtl/vgat_cfg_regs.sv
module vgat_cfg_regs
  import vgat_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic [CTL_W-1:0]       ctl_data,
  input  logic                   mask_we,
  input  logic [NUM_REGIONS-1:0] mask_data,
  output ctl_t                   ctl_q,
  output logic [NUM_REGIONS-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_t'(ctl_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= mask_data;
    end
  end
endmodule

// File: rtl/vgat_range_decode.sv
module vgat_range_decode
  import vgat_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SUB-1:0] sub_en,
  output logic [NUM_SUB-1:0] sub_hit,
  output logic               any_hit
);
  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    assign sub_hit[g] = sub_en[g] && in_span(addr, SUB_LO[g], SUB_HI[g]);
  end
  assign any_hit = |sub_hit;
endmodule

// File: rtl/vgat_region_gate.sv
module vgat_region_gate
  import vgat_pkg::*;
(
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   base_hi,
  input  logic [NUM_REGIONS-1:0] mask,
  output logic                   in_win,
  output logic [IDX_W-1:0]       idx,
  output logic                   gate_open
);
  logic [ADDR_W-1:0] offs;

  always_comb begin
    offs      = win_offset(addr, base_hi);
    in_win    = offs < ADDR_W'(WIN_BYTES);
    idx       = region_of(offs);
    gate_open = in_win ? mask[idx] : 1'b1;
  end
endmodule

// File: rtl/vgat_top.sv
module vgat_top
  import vgat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        cfg_ctl_we,
  input  logic [4:0]  cfg_ctl_data,
  input  logic        cfg_mask_we,
  input  logic [31:0] cfg_mask_data,
  output logic        acc_route,
  output logic        acc_smi
);
  ctl_t                   ctl_q;
  logic [NUM_REGIONS-1:0] mask_q;
  logic [NUM_SUB-1:0]     sub_hit;
  logic                   range_hit;
  logic                   win_hit;
  logic [IDX_W-1:0]       region_idx;
  logic                   region_open;

  vgat_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (cfg_ctl_we),
    .ctl_data  (cfg_ctl_data),
    .mask_we   (cfg_mask_we),
    .mask_data (cfg_mask_data),
    .ctl_q     (ctl_q),
    .mask_q    (mask_q)
  );

  vgat_range_decode u_dec (
    .addr    (acc_addr),
    .sub_en  (ctl_q.sub_en),
    .sub_hit (sub_hit),
    .any_hit (range_hit)
  );

  vgat_region_gate u_gate (
    .addr      (acc_addr),
    .base_hi   (ctl_q.base_hi),
    .mask      (mask_q),
    .in_win    (win_hit),
    .idx       (region_idx),
    .gate_open (region_open)
  );

  // Same-cycle decision (R9): no register between address and outputs.
  assign acc_route = acc_valid && range_hit;
  assign acc_smi   = acc_route && ctl_q.irq_en && region_open;
endmodule

// File: rtl/vgat_checker.sv
module vgat_checker
  import vgat_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [31:0]        acc_addr,
  input logic               cfg_ctl_we,
  input logic [4:0]         cfg_ctl_data,
  input logic               acc_route,
  input logic               acc_smi,
  input logic [NUM_SUB-1:0] sub_hit,
  input logic               win_hit,
  input logic               region_open
);
  assert_sub_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_hit));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_route && !acc_smi));

  assert_route_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_route |-> (acc_addr >= 32'h000A_0000 && acc_addr <= 32'h000B_FFFF));

  assert_smi_needs_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_smi |-> acc_route);

  assert_outside_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> region_open);

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctl_we && !cfg_ctl_data[4]) |=> !acc_smi);

  assert_ctl_takes_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctl_we && cfg_ctl_data[2:0] == 3'b000) |=> !acc_route);
endmodule

bind vgat_top vgat_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_addr     (acc_addr),
  .cfg_ctl_we   (cfg_ctl_we),
  .cfg_ctl_data (cfg_ctl_data),
  .acc_route    (acc_route),
  .acc_smi      (acc_smi),
  .sub_hit      (sub_hit),
  .win_hit      (win_hit),
  .region_open  (region_open)
);

// File: tb/vgat_top_test.sv
module vgat_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        cfg_ctl_we = 1'b0;
  logic [4:0]  cfg_ctl_data = '0;
  logic        cfg_mask_we = 1'b0;
  logic [31:0] cfg_mask_data = '0;
  logic        acc_route;
  logic        acc_smi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  bit [4:0]  m_ctl;
  bit [31:0] m_mask;

  always #2 clk = ~clk;

  vgat_top uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cfg_ctl_we(cfg_ctl_we), .cfg_ctl_data(cfg_ctl_data),
    .cfg_mask_we(cfg_mask_we), .cfg_mask_data(cfg_mask_data),
    .acc_route(acc_route), .acc_smi(acc_smi)
  );

  function automatic bit model_route(bit v, bit [31:0] a, bit [4:0] c);
    bit hit;
    hit = 0;
    if (c[0] && a >= 'hA0000 && a < 'hB0000) hit = 1;
    if (c[1] && a >= 'hB0000 && a < 'hB8000) hit = 1;
    if (c[2] && a >= 'hB8000 && a < 'hC0000) hit = 1;
    return v && hit;
  endfunction

  function automatic bit model_smi(bit v, bit [31:0] a, bit [4:0] c, bit [31:0] m);
    longint base;
    longint rel;
    base = c[3] ? 'hB0000 : 'hA0000;
    rel  = longint'(a) - base;
    if (!model_route(v, a, c) || !c[4]) return 0;
    if (rel < 0 || rel >= 65536) return 1;
    return m[rel / 2048];
  endfunction

  task automatic check(string req, bit got, bit exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h: got %0b expected %0b", req, what, acc_addr, got, exp);
    end
  endtask

  // One clock: drive after negedge, compare before posedge, then update model.
  task automatic step(string req, bit v, bit [31:0] a,
                      bit cwe = 0, bit [4:0] cd = 0, bit mwe = 0, bit [31:0] md = 0);
    @(negedge clk);
    acc_valid = v; acc_addr = a;
    cfg_ctl_we = cwe; cfg_ctl_data = cd;
    cfg_mask_we = mwe; cfg_mask_data = md;
    #1;
    check(req, acc_route, model_route(v, a, m_ctl), "route");
    check(req, acc_smi, model_smi(v, a, m_ctl, m_mask), "smi");
    @(posedge clk);
    if (cwe) m_ctl = cd;
    if (mwe) m_mask = md;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ctl = 0; m_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, nothing enabled
    step("R1", 1, 32'hA0000);
    step("R1", 1, 32'hB8004);
    // R10: write in this cycle is not yet visible
    step("R10", 1, 32'hA1234, 1, 5'b1_0_111);
    // R1: mask reset all ones -> every region interrupts
    for (int i = 0; i < 32; i++) step("R1", 1, 32'hA0000 + i * 2048 + 5);
    // R2 / R4 boundaries
    step("R2", 1, 32'hAFFFF);
    step("R2", 1, 32'hB0000);
    step("R2", 1, 32'hB7FFF);
    step("R2", 1, 32'hB8000);
    step("R2", 1, 32'hBFFFF);
    step("R4", 1, 32'h9FFFF);
    step("R4", 1, 32'hC0000);
    step("R4", 1, 32'h001A_0000);
    step("R4", 1, 32'h8000_B000);
    // R3: valid low
    step("R3", 0, 32'hA0000);
    step("R3", 0, 32'hB9000);
    // R2: disable the monochrome span only
    step("R2", 1, 32'hB4000, 1, 5'b1_0_101);
    step("R4", 1, 32'hB4000);
    step("R2", 1, 32'hB8000);
    step("R2", 1, 32'hA8000);
    // R6 / R10: mask write, old mask visible in write cycle
    step("R10", 1, 32'hA0800, 0, 0, 1, 32'h8000_0001);
    step("R6", 1, 32'hA0000);
    step("R6", 1, 32'hA0800);
    step("R6", 1, 32'hAF800);
    step("R6", 1, 32'hAF7FF);
    // R7: window at A0000h, colour text span outside -> ungated
    step("R7", 1, 32'hB8000, 1, 5'b1_0_111);
    step("R7", 1, 32'hB8000);
    step("R7", 1, 32'hB0800);
    // R6: base at B0000h
    step("R6", 1, 32'hB0000, 1, 5'b1_1_111);
    step("R6", 1, 32'hB0000);
    step("R6", 1, 32'hB0800);
    step("R6", 1, 32'hBF800);
    step("R7", 1, 32'hA0800);
    // R8: interrupt disabled, routing unchanged
    step("R8", 1, 32'hB0000, 1, 5'b0_1_111);
    step("R8", 1, 32'hB0000);
    step("R8", 1, 32'hA4000);
    // R9: address changes every cycle, outputs track
    step("R9", 1, 32'hB8000, 1, 5'b1_0_111, 1, 32'h5555_AAAA);
    for (int i = 0; i < 64; i++) step("R9", 1, 32'hA0000 + i * 2048);
    // R5: mixed sweep against the model every clock
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] a;
      bit cw, mw;
      a  = 32'h90000 + ($urandom % 32'h40000);
      if ($urandom % 64 == 0) a = $urandom;
      cw = ($urandom % 16) == 0;
      mw = ($urandom % 16) == 0;
      step("R5", ($urandom % 8) != 0, a, cw, 5'($urandom), mw, $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule